// File: doc/BRIEF.md
# Flash Program/Erase Pulse Timer

This block controls and times the high-voltage pulses that program or erase an on-chip flash array. Software writes one control word that selects program or erase, picks a clock-range code and a pulse exponent, and holds a configuration lock. Setting the arm bit starts a pulse. The block divides the system clock by a prescale value taken from the range code. The pulse then lasts a power-of-two number of those scaled ticks. A fixed recovery interval follows the pulse. The busy status stays high through both the pulse and the recovery.

While busy is high, array-access requests and low-power clock-stop requests are held without acknowledge. The lock bit cannot move while busy is high. While the lock is set, the timing fields ignore writes. At reset, the range and exponent fields take their values from strap pins. A one-cycle done strobe marks the end of each recovery.

Top module: `flash_hv_timer`

## Requirements
- R1: The control word has this layout: bit 0 is arm, bit 1 is erase select, bit 2 is lock, bits 5:3 are the range code and bits 7:6 are the exponent code. The read word repeats this layout and adds busy at bit 8. Busy is status only, and the write port has no bit for it.
- R2: After reset, busy, arm, lock and erase read 0. The range and exponent fields hold the values on the strap pins.
- R3: The prescale value R is 1 for range code 0 and code+1 for any other code. A pulse that runs to completion keeps busy high for 2^N·R system clocks before recovery starts.
- R4: The exponent N equals 5 + exponent code + 10·erase. N, R and the recovery length are captured from the field values that result from the arming write. Field writes made during the pulse do not change its timing.
- R5: Writing arm=0 during a pulse ends the pulse at once, and recovery starts in the next cycle.
- R6: Recovery lasts 48 scaled ticks. When the captured range code is 0, it lasts 128 clocks instead. Busy stays 1 during recovery. Arm clears itself when the pulse ends, whichever way it ends.
- R7: acc_ack equals acc_req while busy is 0 and is 0 while busy is 1.
- R8: stop_ack equals stop_req while busy is 0 and is 0 while busy is 1.
- R9: While lock reads 1, writes do not change the range, exponent or erase fields.
- R10: Writes to the lock bit are ignored while busy is 1.
- R11: Writing arm=1 while busy is 1 neither restarts nor extends the sequence.
- R12: done is high for exactly one cycle per sequence, in the first cycle in which busy reads 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| strap_range | input | 3 | Reset value of the range code |
| strap_exp | input | 2 | Reset value of the exponent code |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word to write |
| rd_data | output | 9 | Control word readback with busy at bit 8 |
| acc_req | input | 1 | Array access request |
| acc_ack | output | 1 | Array access acknowledge |
| stop_req | input | 1 | Low-power clock-stop request |
| stop_ack | output | 1 | Clock-stop acknowledge |
| done | output | 1 | One-cycle strobe at the end of recovery |

## Verification
The important same-cycle collisions involve a write and a sequence event. One is a write that clears arm or sets lock landing while the pulse timer or the recovery counter is running. The other is a field write landing in the same cycle as the arming that captures those fields. The bench arms a short pulse and then writes new fields, lock=1 and arm=1 in the middle of it. It writes arm=1 again in recovery, and in a long erase pulse it writes a disarm partway through. It judges each case by the exact number of busy cycles, which the bench computes from R, N and the recovery rule. It also checks the readback of the lock, arm and field bits straight after each write.

// File: rtl/flash_hv_pkg.sv
package flash_hv_pkg;

  localparam int HV_RANGE_W = 3;
  localparam int HV_EXP_W   = 2;

  typedef enum logic [1:0] {
    HV_IDLE  = 2'd0,
    HV_PULSE = 2'd1,
    HV_RECOV = 2'd2
  } hv_state_e;

  // Control word layout, MSB first.
  typedef struct packed {
    logic [HV_EXP_W-1:0]   exp_code;
    logic [HV_RANGE_W-1:0] range_code;
    logic                  lock;
    logic                  erase;
    logic                  arm;
  } hv_ctl_t;

  localparam int HV_CTL_W = $bits(hv_ctl_t);

  // Prescale minus one: code 0 divides by 1, code k by k+1.
  function automatic logic [HV_RANGE_W-1:0] hv_div_minus1(
    input logic [HV_RANGE_W-1:0] code
  );
    logic [HV_RANGE_W-1:0] r;
    if (code == '0) r = '0;
    else            r = code;
    return r;
  endfunction

endpackage

// File: rtl/flash_hv_prescale.sv
module flash_hv_prescale
  import flash_hv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  clear,
  input  logic [HV_RANGE_W-1:0] rm1,
  output logic                  tick
);

  logic [HV_RANGE_W-1:0] div_q, div_nx;
  logic                  div_en;

  assign tick   = run && !clear && (div_q == rm1);
  assign div_en = run || clear;

  always_comb begin
    div_nx = div_q;
    if (clear)     div_nx = '0;
    else if (tick) div_nx = '0;
    else if (run)  div_nx = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_nx;
  end

endmodule

// File: rtl/flash_hv_regs.sv
module flash_hv_regs
  import flash_hv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [HV_RANGE_W-1:0] strap_range,
  input  logic [HV_EXP_W-1:0]   strap_exp,
  input  logic                  wr_en,
  input  hv_ctl_t               wr_ctl,
  input  logic                  busy,
  input  logic                  pulse_end,
  output hv_ctl_t               ctl_q,
  output hv_ctl_t               ctl_nx,
  output logic                  start,
  output logic                  abort
);

  logic ctl_en;

  always_comb begin
    ctl_nx = ctl_q;
    start  = 1'b0;
    abort  = 1'b0;
    if (wr_en) begin
      if (!ctl_q.lock) begin
        ctl_nx.exp_code   = wr_ctl.exp_code;
        ctl_nx.range_code = wr_ctl.range_code;
        ctl_nx.erase      = wr_ctl.erase;
      end
      if (!busy) ctl_nx.lock = wr_ctl.lock;
      if (wr_ctl.arm && !busy) begin
        ctl_nx.arm = 1'b1;
        start      = 1'b1;
      end else if (!wr_ctl.arm && ctl_q.arm) begin
        ctl_nx.arm = 1'b0;
        abort      = 1'b1;
      end
    end
    if (pulse_end) ctl_nx.arm = 1'b0;
  end

  assign ctl_en = wr_en || pulse_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.exp_code   <= strap_exp;
      ctl_q.range_code <= strap_range;
      ctl_q.lock       <= 1'b0;
      ctl_q.erase      <= 1'b0;
      ctl_q.arm        <= 1'b0;
    end else if (ctl_en) begin
      ctl_q <= ctl_nx;
    end
  end

endmodule

// File: rtl/flash_hv_seq.sv
module flash_hv_seq
  import flash_hv_pkg::*;
#(
  parameter int EXP_BASE       = 5,
  parameter int ERASE_ADD      = 10,
  parameter int REC_TICKS      = 48,
  parameter int REC_TICKS_SLOW = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  abort,
  input  hv_ctl_t               cfg,
  input  logic                  tick,
  output logic                  busy,
  output logic                  pulse_end,
  output logic                  phase_clr,
  output logic [HV_RANGE_W-1:0] rm1,
  output logic                  done
);

  localparam int N_W   = 6;
  localparam int N_MAX = EXP_BASE + (1 << HV_EXP_W) - 1 + ERASE_ADD;
  localparam int REC_MAX = (REC_TICKS > REC_TICKS_SLOW) ? REC_TICKS : REC_TICKS_SLOW;
  localparam int REC_W = $clog2(REC_MAX + 1);
  localparam int CNT_W = (N_MAX > REC_W) ? N_MAX : REC_W;

  hv_state_e             state_q, state_nx;
  logic [CNT_W-1:0]      cnt_q, cnt_nx;
  logic [N_W-1:0]        n_q, n_nx;
  logic [HV_RANGE_W-1:0] rm1_q, rm1_nx;
  logic                  slow_q, slow_nx;
  logic                  done_q, done_nx;
  logic                  cap_en;
  logic [CNT_W-1:0]      pulse_lim, rec_lim;

  assign pulse_lim = (CNT_W'(1) << n_q) - CNT_W'(1);
  assign rec_lim   = slow_q ? CNT_W'(REC_TICKS_SLOW - 1) : CNT_W'(REC_TICKS - 1);

  always_comb begin
    state_nx  = state_q;
    cnt_nx    = cnt_q;
    n_nx      = N_W'(EXP_BASE) + N_W'(cfg.exp_code) + (cfg.erase ? N_W'(ERASE_ADD) : '0);
    rm1_nx    = hv_div_minus1(cfg.range_code);
    slow_nx   = (cfg.range_code == '0);
    cap_en    = 1'b0;
    pulse_end = 1'b0;
    phase_clr = 1'b0;
    done_nx   = 1'b0;
    unique case (state_q)
      HV_IDLE: begin
        if (start) begin
          state_nx  = HV_PULSE;
          cnt_nx    = '0;
          cap_en    = 1'b1;
          phase_clr = 1'b1;
        end
      end
      HV_PULSE: begin
        if (abort) begin
          state_nx  = HV_RECOV;
          cnt_nx    = '0;
          phase_clr = 1'b1;
        end else if (tick) begin
          if (cnt_q == pulse_lim) begin
            state_nx  = HV_RECOV;
            cnt_nx    = '0;
            pulse_end = 1'b1;
          end else begin
            cnt_nx = cnt_q + 1'b1;
          end
        end
      end
      HV_RECOV: begin
        if (tick) begin
          if (cnt_q == rec_lim) begin
            state_nx = HV_IDLE;
            cnt_nx   = '0;
            done_nx  = 1'b1;
          end else begin
            cnt_nx = cnt_q + 1'b1;
          end
        end
      end
      default: state_nx = HV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HV_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      cnt_q   <= cnt_nx;
      done_q  <= done_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q    <= '0;
      rm1_q  <= '0;
      slow_q <= 1'b0;
    end else if (cap_en) begin
      n_q    <= n_nx;
      rm1_q  <= rm1_nx;
      slow_q <= slow_nx;
    end
  end

  assign busy = (state_q != HV_IDLE);
  assign rm1  = rm1_q;
  assign done = done_q;

endmodule

// File: rtl/flash_hv_timer.sv
module flash_hv_timer
  import flash_hv_pkg::*;
#(
  parameter int EXP_BASE       = 5,
  parameter int ERASE_ADD      = 10,
  parameter int REC_TICKS      = 48,
  parameter int REC_TICKS_SLOW = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [HV_RANGE_W-1:0] strap_range,
  input  logic [HV_EXP_W-1:0]   strap_exp,
  input  logic                  wr_en,
  input  logic [HV_CTL_W-1:0]   wr_data,
  output logic [HV_CTL_W:0]     rd_data,
  input  logic                  acc_req,
  output logic                  acc_ack,
  input  logic                  stop_req,
  output logic                  stop_ack,
  output logic                  done
);

  logic rst_meta_n, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  hv_ctl_t               wr_ctl, ctl_q, ctl_nx;
  logic                  busy, start, abort, pulse_end, phase_clr, tick;
  logic [HV_RANGE_W-1:0] rm1;

  assign wr_ctl = hv_ctl_t'(wr_data);

  flash_hv_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .strap_range(strap_range),
    .strap_exp  (strap_exp),
    .wr_en      (wr_en),
    .wr_ctl     (wr_ctl),
    .busy       (busy),
    .pulse_end  (pulse_end),
    .ctl_q      (ctl_q),
    .ctl_nx     (ctl_nx),
    .start      (start),
    .abort      (abort)
  );

  flash_hv_seq #(
    .EXP_BASE      (EXP_BASE),
    .ERASE_ADD     (ERASE_ADD),
    .REC_TICKS     (REC_TICKS),
    .REC_TICKS_SLOW(REC_TICKS_SLOW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start    (start),
    .abort    (abort),
    .cfg      (ctl_nx),
    .tick     (tick),
    .busy     (busy),
    .pulse_end(pulse_end),
    .phase_clr(phase_clr),
    .rm1      (rm1),
    .done     (done)
  );

  flash_hv_prescale u_pre (
    .clk  (clk),
    .rst_n(rst_q_n),
    .run  (busy),
    .clear(phase_clr),
    .rm1  (rm1),
    .tick (tick)
  );

  assign rd_data  = {busy, ctl_q};
  assign acc_ack  = acc_req && !busy;
  assign stop_ack = stop_req && !busy;

endmodule

// File: rtl/flash_hv_checker.sv
module flash_hv_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] rd_data,
  input logic       acc_req,
  input logic       acc_ack,
  input logic       stop_req,
  input logic       stop_ack,
  input logic       done
);

  logic       busy, arm, lock, erase;
  logic [2:0] range_f;
  logic [1:0] exp_f;

  assign busy    = rd_data[8];
  assign exp_f   = rd_data[7:6];
  assign range_f = rd_data[5:3];
  assign lock    = rd_data[2];
  assign erase   = rd_data[1];
  assign arm     = rd_data[0];

  a_r7_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !acc_ack);
  a_r7_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !busy) |-> acc_ack);
  a_r8_stop_refused: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !stop_ack);
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !busy) |-> stop_ack);
  a_r10_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lock));
  a_r9_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(range_f) && $stable(exp_f) && $stable(erase)));
  a_r6_arm_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> busy);
  a_r11_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !arm) |=> !arm);
  a_r12_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind flash_hv_timer flash_hv_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .rd_data (rd_data),
  .acc_req (acc_req),
  .acc_ack (acc_ack),
  .stop_req(stop_req),
  .stop_ack(stop_ack),
  .done    (done)
);

// File: tb/sim_flash_hv_timer.sv
module sim_flash_hv_timer;

  logic       clk;
  logic       rst_n;
  logic [2:0] strap_range;
  logic [1:0] strap_exp;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [8:0] rd_data;
  logic       acc_req, acc_ack, stop_req, stop_ack, done;

  int n_run  = 0;
  int n_fail = 0;
  int busy_cnt = 0;
  int done_cnt = 0;
  int done_bad = 0;

  flash_hv_timer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_range(strap_range),
    .strap_exp  (strap_exp),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .acc_req    (acc_req),
    .acc_ack    (acc_ack),
    .stop_req   (stop_req),
    .stop_ack   (stop_ack),
    .done       (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rd_data[8] === 1'b1) busy_cnt++;
    if (done === 1'b1) begin
      done_cnt++;
      if (rd_data[8] !== 1'b0) done_bad++;
    end
  end

  function automatic logic [7:0] mk(input logic arm, input logic erase, input logic lock,
                                    input logic [2:0] rng, input logic [1:0] ex);
    return {ex, rng, lock, erase, arm};
  endfunction

  function automatic int exp_busy(input int rng, input int ex, input int erase);
    int r, n, k;
    r = (rng == 0) ? 1 : rng + 1;
    n = 5 + ex + 10 * erase;
    k = (rng == 0) ? 128 : 48;
    return (1 << n) * r + k * r;
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic clr_mon();
    #1;
    busy_cnt = 0;
    done_cnt = 0;
  endtask

  task automatic wait_idle();
    while (rd_data[8] === 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n       = 1'b0;
    strap_range = 3'd5;
    strap_exp   = 2'd2;
    wr_en       = 1'b0;
    wr_data     = '0;
    acc_req     = 1'b1;
    stop_req    = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state with strap values
    check("R2 reset word", int'(rd_data), int'({1'b0, 2'd2, 3'd5, 3'b000}));
    check("R7 ack idle", int'(acc_ack), 1);
    check("R8 stop idle", int'(stop_ack), 1);

    // R1/R9: write unlocked, then locked writes are ignored
    wr(mk(0, 0, 1, 3'd2, 2'd1));
    check("R1 readback", int'(rd_data), int'({1'b0, 2'd1, 3'd2, 3'b100}));
    wr(mk(0, 1, 1, 3'd6, 2'd3));
    check("R9 range locked", int'(rd_data[5:3]), 2);
    check("R9 exp locked", int'(rd_data[7:6]), 1);
    check("R9 erase locked", int'(rd_data[1]), 0);
    wr(mk(0, 0, 0, 3'd0, 2'd0));
    check("R9 unlock keeps range", int'(rd_data[5:3]), 2);
    check("R1 lock cleared", int'(rd_data[2]), 0);

    // R4/R6/R10/R11: short pulse with writes during pulse and recovery
    wr(mk(0, 0, 0, 3'd0, 2'd0));
    clr_mon();
    wr(mk(1, 0, 0, 3'd0, 2'd0));
    check("R6 arm set", int'(rd_data[0]), 1);
    check("R1 busy set", int'(rd_data[8]), 1);
    check("R7 ack held", int'(acc_ack), 0);
    check("R8 stop refused", int'(stop_ack), 0);
    wr(mk(1, 0, 1, 3'd7, 2'd3));
    check("R10 lock ignored", int'(rd_data[2]), 0);
    check("R4 field written", int'(rd_data[5:3]), 7);
    repeat (40) @(negedge clk);
    check("R6 arm self-clear", int'(rd_data[0]), 0);
    check("R6 busy in recovery", int'(rd_data[8]), 1);
    wr(mk(1, 0, 0, 3'd7, 2'd3));
    check("R11 rearm ignored", int'(rd_data[0]), 0);
    wait_idle();
    check("R4 captured timing", busy_cnt, 160);
    check("R12 done once", done_cnt, 1);
    check("R7 ack after", int'(acc_ack), 1);
    check("R8 stop after", int'(stop_ack), 1);

    // R4: erase pulse length
    wr(mk(0, 1, 0, 3'd0, 2'd0));
    clr_mon();
    wr(mk(1, 1, 0, 3'd0, 2'd0));
    wait_idle();
    check("R4 erase length", busy_cnt, exp_busy(0, 0, 1));
    check("R12 done erase", done_cnt, 1);

    // R5: early termination
    wr(mk(0, 1, 0, 3'd1, 2'd0));
    clr_mon();
    wr(mk(1, 1, 0, 3'd1, 2'd0));
    repeat (20) @(negedge clk);
    wr(mk(0, 1, 0, 3'd1, 2'd0));
    check("R5 arm cleared", int'(rd_data[0]), 0);
    check("R5 recovery busy", int'(rd_data[8]), 1);
    wait_idle();
    check("R5 abort length", busy_cnt, 22 + 96);
    check("R12 done abort", done_cnt, 1);

    // R3: random program pulses
    for (int i = 0; i < 8; i++) begin
      int rg, ex;
      rg = int'($urandom_range(7, 0));
      ex = int'($urandom_range(3, 0));
      wr(mk(0, 0, 0, 3'(rg), 2'(ex)));
      clr_mon();
      wr(mk(1, 0, 0, 3'(rg), 2'(ex)));
      check("R7 ack held rnd", int'(acc_ack), 0);
      wait_idle();
      check("R3 pulse length", busy_cnt, exp_busy(rg, ex, 0));
      check("R12 done rnd", done_cnt, 1);
      check("R6 arm clear rnd", int'(rd_data[0]), 0);
    end

    check("R12 done only when idle", done_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule